// File: doc/BRIEF.md
# Pipelined Burst SRAM with Sleep Sequencing

This block is a synthesizable behavioural model of a single-port synchronous SRAM with a small array, for use wherever such a memory has to sit in a simulation or prototype netlist. On each rising clock edge it samples an address, a write command with per-byte enables, three chip enables, an active-low load strobe and an active-low clock enable. A load captures a new address. While the strobe is held high, later edges step through the other words of the same aligned group of four, in linear or interleaved order.

Read data leaves through a register pipeline of parameterised depth. The output carries a drive flag: when the flag is low the data pins are to be treated as high-impedance, and the data value then reads zero. The output enable clears the drive flag asynchronously. A deselect empties the result slot it occupies, and the sleep input takes the whole part out of service through a two-edge entry and a two-edge recovery. Every pin here is a plain memory pin with no flow control, so no valid/ready handshake appears.

Write data is taken on the same edge as its address. The array is not cleared by reset.

Top module: `sram_burst_top`

## Requirements
- R1: An access starts only on an edge where load_n=0, en_a_n=0, en_b=1 and en_c_n=0. Any other enable combination on a load edge is a deselect: nothing is written, and rdata_drv is 0 in the result slot of that edge.
- R2: A loaded access is a write when we_n=0 and at least one bit of bw_n is 0. Otherwise, including we_n=0 with bw_n all ones, it is a read.
- R3: Byte lane i, which is wdata[8i+7:8i], is written only when bw_n[i]=0 on that beat. Lanes whose bit is 1 keep their contents.
- R4: With order_sel=0, advance edges (load_n=1) of an active burst use the loaded address with its low two bits replaced by (base+n) mod 4, where n counts beats from 0 at the load edge. The fifth beat wraps back to the loaded word. On advance edges the enables and we_n are ignored, and the burst keeps the read or write type of its load.
- R5: With order_sel=1, the low two bits of beat n are base XOR n.
- R6: Read data for a beat sampled at an enabled edge is on rdata with rdata_drv=1 after LAT enabled edges, the sampling edge included (LAT=2 by default). After reset, rdata_drv=0.
- R7: An edge with cke_n=1 samples nothing and writes nothing, and rdata and rdata_drv hold their values.
- R8: oe_n=1 forces rdata_drv=0 without waiting for a clock edge. Whenever rdata_drv=0, rdata reads 0.
- R9: A deselect ends any burst. Advance edges with no active burst, whether after a deselect or after reset, behave as deselects.
- R10: Inputs, writes included, are sampled on the first two edges at which sleep is 1. From the next edge on, all inputs other than sleep are ignored, the pipeline holds, and rdata_drv is 0.
- R11: After sleep returns to 0, the first two edges are still ignored and rdata_drv stays 0. Once the second of them has passed, the held pipeline drives again, and the third edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low: load new address; high: advance burst |
| we_n | input | 1 | Active-low write command |
| bw_n | input | NB | Active-low byte-write enables |
| addr | input | AW | Word address |
| wdata | input | 8*NB | Write data |
| oe_n | input | 1 | Active-low output enable (asynchronous) |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| sleep | input | 1 | Sleep request |
| rdata | output | 8*NB | Read data, 0 when not driven |
| rdata_drv | output | 1 | Output driver on; low means high-impedance |

## Verification
Single reads issued back to back show that each result lands exactly LAT edges after its load, because every slot carries a different word. A burst loaded mid-group is read in both orders and run past four beats, which separates linear from interleaved stepping and shows the wrap. Partial byte masks on top of known data pick out each lane, and a write command with no lane enabled reads the word back instead. Each illegal enable pattern is followed by advance edges to show that no burst survives it. A read left in the pipeline before sleep shows that it is held through sleep and recovery and hidden only while asleep, while writes placed on every entry, sleep and recovery edge show which of those edges are sampled.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic [1:0] {
    SLP_AWAKE  = 2'd0,
    SLP_ENTER  = 2'd1,
    SLP_ASLEEP = 2'd2,
    SLP_WAKE   = 2'd3
  } slp_state_t;

  // Low two address bits of burst beat n.
  function automatic logic [1:0] beat_offset(input logic [1:0] base_lo,
                                             input logic [1:0] n,
                                             input logic       interleave);
    return interleave ? (base_lo ^ n) : (base_lo + n);
  endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          load,
  input  logic          sel,
  input  logic          wr_cmd,
  input  logic          order_sel,
  input  logic [AW-1:0] addr,
  output logic          acc_valid,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          active_q;
  logic          wr_q;
  logic [AW-1:0] base_cur;
  logic [1:0]    beat_n;

  always_comb begin
    base_cur  = load ? addr : base_q;
    beat_n    = load ? 2'd0 : cnt_q;
    acc_addr  = {base_cur[AW-1:2], beat_offset(base_cur[1:0], beat_n, order_sel)};
    acc_valid = take && (load ? sel : active_q);
    acc_wr    = load ? wr_cmd : wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (take) begin
      if (load) begin
        active_q <= sel;
        base_q   <= addr;
        wr_q     <= wr_cmd;
        cnt_q    <= 2'd1;
      end else if (active_q) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  AST_NO_ORPHAN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load && !active_q) |-> !acc_valid); // R9

  AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel) |-> !acc_valid); // R1

endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sram_burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic ignore_in,
  output logic force_hiz
);

  slp_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLP_AWAKE:  if (sleep) state_d = SLP_ENTER;
      SLP_ENTER:  state_d = sleep ? SLP_ASLEEP : SLP_AWAKE;
      SLP_ASLEEP: if (!sleep) state_d = SLP_WAKE;
      SLP_WAKE:   state_d = sleep ? SLP_ASLEEP : SLP_AWAKE;
      default:    state_d = SLP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLP_AWAKE;
    else        state_q <= state_d;
  end

  assign ignore_in = (state_q == SLP_ASLEEP) || (state_q == SLP_WAKE);
  assign force_hiz = ignore_in;

  AST_ENTER_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ignore_in) |-> ($past(sleep) && $past(sleep, 2))); // R10

  AST_EXIT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ignore_in) |-> (!$past(sleep) && !$past(sleep, 2))); // R11

endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe #(
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic          v_q [LAT];
  logic [DW-1:0] d_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        v_q[i] <= 1'b0;
        d_q[i] <= '0;
      end
    end else if (adv) begin
      v_q[0] <= in_valid;
      d_q[0] <= in_valid ? in_data : '0;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_data  = d_q[LAT-1];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(out_valid) && $stable(out_data))); // R7

endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top
  import sram_burst_pkg::*;
#(
  parameter int AW  = 6,
  parameter int NB  = 4,
  parameter int LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke_n,
  input  logic            en_a_n,
  input  logic            en_b,
  input  logic            en_c_n,
  input  logic            load_n,
  input  logic            we_n,
  input  logic [NB-1:0]   bw_n,
  input  logic [AW-1:0]   addr,
  input  logic [8*NB-1:0] wdata,
  input  logic            oe_n,
  input  logic            order_sel,
  input  logic            sleep,
  output logic [8*NB-1:0] rdata,
  output logic            rdata_drv
);

  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic          ignore_in;
  logic          force_hiz;
  logic          take;
  logic          sel;
  logic          wr_cmd;
  logic          acc_valid;
  logic          acc_wr;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] rd_word;
  logic          pipe_valid;
  logic [DW-1:0] pipe_data;

  assign take   = !cke_n && !ignore_in;
  assign sel    = !en_a_n && en_b && !en_c_n;
  assign wr_cmd = !we_n && (bw_n != '1);

  sram_sleep_ctrl u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .ignore_in (ignore_in),
    .force_hiz (force_hiz)
  );

  sram_burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .load      (!load_n),
    .sel       (sel),
    .wr_cmd    (wr_cmd),
    .order_sel (order_sel),
    .addr      (addr),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr)
  );

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic       lane_we;

    assign lane_we = acc_valid && acc_wr && !bw_n[l];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[acc_addr] <= wdata[8*l +: 8];
    end

    assign rd_word[8*l +: 8] = lane_mem[acc_addr];
  end

  sram_read_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (take),
    .in_valid  (acc_valid && !acc_wr),
    .in_data   (rd_word),
    .out_valid (pipe_valid),
    .out_data  (pipe_data)
  );

  assign rdata_drv = pipe_valid && !oe_n && !force_hiz;
  assign rdata     = rdata_drv ? pipe_data : '0;

  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_drv); // R8

  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_in |-> !rdata_drv); // R10

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_drv |-> (rdata == '0)); // R8

endmodule

// File: tb/sram_burst_top_tb_top.sv
module sram_burst_top_tb_top;

  localparam int AW  = 6;
  localparam int NB  = 4;
  localparam int LAT = 2;
  localparam int DW  = 8 * NB;
  localparam logic [2:0] SEL  = 3'b010; // {en_a_n, en_b, en_c_n}
  localparam logic [2:0] DSEL = 3'b110;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke_n, en_a_n, en_b, en_c_n, load_n, we_n, oe_n, order_sel, sleep;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_drv;

  logic [DW-1:0] mdl [1 << AW];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_burst_top #(.AW(AW), .NB(NB), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .load_n(load_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .order_sel(order_sel), .sleep(sleep),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic ld, input logic [2:0] en, input logic we,
                     input logic [NB-1:0] bw, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    load_n = !ld;
    {en_a_n, en_b, en_c_n} = en;
    we_n = we;
    bw_n = bw;
    addr = a;
    wdata = d;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] bw);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NB; l++) if (!bw[l]) r[8*l +: 8] = nw[8*l +: 8];
    return r;
  endfunction

  task automatic chk(input logic exp_drv, input logic [DW-1:0] exp_d, input string tag);
    logic [DW-1:0] e;
    e = exp_drv ? exp_d : '0;
    n_chk++;
    if (rdata_drv !== exp_drv || rdata !== e) begin
      n_fail++;
      $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h", tag, rdata_drv, rdata, exp_drv, e);
    end
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] bw);
    cmd(1, SEL, 0, bw, a, d);
    cyc();
    mdl[a] = merge(mdl[a], d, bw);
  endtask

  task automatic dsel();
    cmd(1, DSEL, 1, '1, '0, '0);
    cyc();
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    cmd(1, SEL, 1, '1, a, '0);
    cyc();
    dsel();
    chk(1, mdl[a], tag);
  endtask

  task automatic t_reset();
    chk(0, '0, "R6 reset state");
  endtask

  task automatic t_latency();
    for (int i = 8; i < 12; i++) wr1(6'(i), 32'hA000_0000 + 32'(i * 32'h0101), '0);
    cmd(1, SEL, 1, '1, 8, '0);  cyc();
    chk(0, '0, "R6 not yet after one edge");
    cmd(1, SEL, 1, '1, 9, '0);  cyc();
    chk(1, mdl[8], "R6 read 8 after LAT edges");
    cmd(1, SEL, 1, '1, 10, '0); cyc();
    chk(1, mdl[9], "R6 read 9 back to back");
    dsel();
    chk(1, mdl[10], "R6 read 10 back to back");
    dsel();
    chk(0, '0, "R1 deselect slot");
  endtask

  task automatic t_bytes();
    wr1(12, 32'h1122_3344, '0);
    wr1(12, 32'hAABB_CCDD, 4'b1010);
    rd_chk(12, "R3 lanes 0 and 2 only");
    cmd(1, SEL, 0, 4'b1111, 12, 32'hDEAD_BEEF); cyc();
    dsel();
    chk(1, mdl[12], "R2 we_n low with no lane is a read");
    wr1(13, 32'h5566_7788, '0);
    wr1(13, 32'h0000_0000, 4'b0111);
    rd_chk(13, "R3 lane 3 only");
  endtask

  task automatic t_burst_lin();
    order_sel = 0;
    cmd(1, SEL, 0, '0, 17, 32'hB000_0017); cyc(); mdl[17] = 32'hB000_0017;
    cmd(0, DSEL, 1, '0, 0, 32'hB000_0018); cyc(); mdl[18] = 32'hB000_0018;
    cmd(0, DSEL, 1, '0, 0, 32'hB000_0019); cyc(); mdl[19] = 32'hB000_0019;
    cmd(0, DSEL, 1, '0, 0, 32'hB000_0016); cyc(); mdl[16] = 32'hB000_0016;
    dsel(); dsel();
    cmd(1, SEL, 1, '1, 18, '0); cyc();
    cmd(0, DSEL, 0, '0, 0, '0); cyc(); chk(1, mdl[18], "R4 linear beat 0");
    cyc(); chk(1, mdl[19], "R4 linear beat 1");
    cyc(); chk(1, mdl[16], "R4 linear beat 2 wraps in group");
    cyc(); chk(1, mdl[17], "R4 linear beat 3");
    dsel(); chk(1, mdl[18], "R4 fifth beat returns to loaded word");
    dsel(); chk(0, '0, "R1 deselect after burst");
  endtask

  task automatic t_burst_int();
    order_sel = 1;
    cmd(1, SEL, 1, '1, 17, '0); cyc();
    cmd(0, SEL, 1, '1, 0, '0); cyc(); chk(1, mdl[17], "R5 interleaved beat 0");
    cyc(); chk(1, mdl[16], "R5 interleaved beat 1");
    cyc(); chk(1, mdl[19], "R5 interleaved beat 2");
    dsel(); chk(1, mdl[18], "R5 interleaved beat 3");
    dsel();
    order_sel = 0;
  endtask

  task automatic t_deselect();
    logic [2:0] bad [3] = '{3'b110, 3'b000, 3'b011};
    foreach (bad[k]) begin
      cmd(1, SEL, 1, '1, 8, '0); cyc();
      cmd(1, bad[k], 0, '0, 9, 32'hBAD0_0000); cyc();
      chk(1, mdl[8], "R1 prior read still emerges");
      cmd(0, SEL, 1, '1, 0, '0); cyc();
      chk(0, '0, "R1 bad enable combination gives deselect slot");
      cyc();
      chk(0, '0, "R9 advance after deselect");
      dsel();
    end
    rd_chk(9, "R1 deselected write left word intact");
    cmd(1, SEL, 1, '1, 16, '0); cyc();
    cmd(0, SEL, 1, '1, 0, '0);  cyc(); chk(1, mdl[16], "R9 burst beat 0");
    dsel();                            chk(1, mdl[17], "R9 burst beat 1");
    cmd(0, SEL, 1, '1, 0, '0);  cyc(); chk(0, '0, "R9 deselect slot");
    cyc();                             chk(0, '0, "R9 burst ended by deselect");
    dsel();
  endtask

  task automatic t_stall();
    dsel(); dsel();
    cmd(1, SEL, 1, '1, 9, '0); cyc();
    cke_n = 1;
    cmd(1, SEL, 0, '0, 9, 32'hFFFF_0000); cyc();
    chk(0, '0, "R7 output holds on stalled edge");
    cyc();
    chk(0, '0, "R7 output holds on second stalled edge");
    cke_n = 0;
    dsel();
    chk(1, mdl[9], "R7 stalled write ignored, read resumes");
    dsel();
  endtask

  task automatic t_oe();
    cmd(1, SEL, 1, '1, 10, '0); cyc();
    dsel();
    chk(1, mdl[10], "R8 driven with oe_n low");
    oe_n = 1; #0.5;
    chk(0, '0, "R8 oe_n high releases output without edge");
    oe_n = 0; #0.5;
    chk(1, mdl[10], "R8 output returns with oe_n low");
    dsel();
  endtask

  task automatic t_sleep();
    for (int i = 20; i < 25; i++) wr1(6'(i), 32'hC000_0000 + 32'(i), '0);
    dsel(); dsel();
    sleep = 1;
    cmd(1, SEL, 1, '1, 8, '0); cyc();                       // first edge with sleep: sampled
    cmd(1, SEL, 0, '0, 20, 32'h5151_5151); cyc();            // second: sampled
    mdl[20] = 32'h5151_5151;
    chk(0, '0, "R10 outputs high-Z once asleep");
    cmd(1, SEL, 0, '0, 21, 32'h6161_6161); cyc();            // ignored
    chk(0, '0, "R10 still high-Z while asleep");
    sleep = 0;
    cmd(1, SEL, 0, '0, 22, 32'h7171_7171); cyc();            // recovery 1: ignored
    chk(0, '0, "R11 high-Z in recovery");
    cmd(1, SEL, 0, '0, 23, 32'h8181_8181); cyc();            // recovery 2: ignored
    chk(1, mdl[8], "R11 held read drives after recovery");
    cmd(1, SEL, 0, '0, 24, 32'h9191_9191); cyc();            // sampled
    mdl[24] = 32'h9191_9191;
    chk(0, '0, "R11 pipeline advances on third edge");
    rd_chk(20, "R10 write on second sleep edge taken");
    rd_chk(21, "R10 write while asleep ignored");
    rd_chk(22, "R11 write on first recovery edge ignored");
    rd_chk(23, "R11 write on second recovery edge ignored");
    rd_chk(24, "R11 write on third edge taken");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_n = 0; cke_n = 0; oe_n = 0; order_sel = 0; sleep = 0;
    cmd(1, DSEL, 1, '1, '0, '0);
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_latency();
    t_bytes();
    t_burst_lin();
    t_burst_int();
    t_deselect();
    t_stall();
    t_oe();
    t_sleep();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: drv=%0b data=%h expected run to complete", rdata_drv, rdata);
      summary();
      $finish;
    end
  end

endmodule